// File: doc/BRIEF.md
# Dual Down-Counting Timer Peripheral

This block holds two independent 32-bit down-counters behind a single word-addressed register window. Software loads a start value, picks periodic or one-shot behaviour and enables the counter. The counter then steps down once per clock. When it runs out it raises a sticky status flag, and it can drive that timer's own interrupt line. In periodic mode the counter reloads and keeps going. In one-shot mode it parks at zero and drops its enable.

Two load paths exist. A write to the immediate load word restarts a running count at once. A write to the deferred load word changes only the value used at the next reload, so the period can be retuned without a glitch in the current one. The upper address bits pick the timer. Each timer owns an 8-word block. Addresses past the second block read as zero and ignore writes.

Top module: `twin_countdown_timer`

## Requirements
- R1: While reset is asserted and after it is released, every register of both timers reads zero and both `irq` bits are low.
- R2: The control word (index 3) holds the enable in bit 0, one-shot in bit 1 and interrupt enable in bit 2, and reads back zero-extended. A control write with bit 0 set loads the counter from the load word and starts counting. A control write with bit 0 clear freezes the count.
- R3: While enabled and not being restarted, the value word (index 0) reads the live count, and the count drops by one each clock while it is above 1.
- R4: An expiry happens in a clock where an enabled, non-restarted counter holds 0 or 1. The expiry sets bit 0 of the raw status word (index 4). In periodic mode the counter takes the load value in that same clock.
- R5: In one-shot mode an expiry leaves the count at 0 and clears control bit 0. A control write in the same clock takes priority over that clear.
- R6: Writing the raw status word with bit 0 = 1 clears the flag, and bit 0 = 0 has no effect. An expiry in the same clock as a clear leaves the flag set.
- R7: The masked status word (index 5) and `irq[n]` both equal raw status bit 0 ANDed with control bit 2.
- R8: A write to the load word (index 1) stores the value. If the timer is enabled, the counter restarts from the written value in that clock, and no expiry occurs in that clock.
- R9: A write to the background load word (index 2) updates both the background and load words and leaves the running count undisturbed. If an expiry reloads in the same clock, it uses the written value.
- R10: Address bits [4:3] = 0 select timer 0 and = 1 select timer 1, with bits [2:0] as the register index. Indices 6–7 and addresses 16–31 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 5 | Word address (timer select and register index) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 2 | Per-timer interrupt, bit n for timer n |

## Verification
The hardest cases to reach are collisions between a register write and an expiry in the same clock. Examples are a background-load write as the count wraps, a status clear as the flag is being set, and a control write as a one-shot drops its enable. Stimulus keeps load values small (1 to 12) so both counters expire every few clocks. Random writes land on the live registers about a third of the time, so these collisions occur many times per run. The bench model applies the priority rules stated in R5, R6 and R9 to predict each outcome.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register indices inside one timer block
  localparam int IDX_VALUE = 0;
  localparam int IDX_LOAD  = 1;
  localparam int IDX_BGLD  = 2;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_RAW   = 4;
  localparam int IDX_MASK  = 5;

  localparam int CTRL_W = 3;

  // bit 2 irq enable, bit 1 one-shot, bit 0 run
  typedef struct packed {
    logic irq_en;
    logic one_shot;
    logic run;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode #(
  parameter int NUM_TIMERS  = 2,
  parameter int BLOCK_WORDS = 8,
  parameter int ADDR_W      = 5,
  localparam int IDX_W      = $clog2(BLOCK_WORDS),
  localparam int CH_W       = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_TIMERS-1:0] sel,
  output logic [NUM_TIMERS-1:0] wr_sel
);

  logic [CH_W-1:0] chan;

  assign chan = addr[ADDR_W-1:IDX_W];
  assign idx  = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_sel
    assign sel[g]    = (chan == CH_W'(g));
    assign wr_sel[g] = wr_en && sel[g];
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import tmr_pkg::*;

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] v);
    return v - DATA_W'(1);
  endfunction

  function automatic logic is_last(input logic [DATA_W-1:0] v);
    return (v == '0) || (v == DATA_W'(1));
  endfunction

  tmr_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] count_q, load_q, bgld_q;
  logic              raw_q;

  // named internal events
  logic ctrl_wr, load_wr, bgld_wr, raw_wr;
  logic advance, expire, restart;
  logic [DATA_W-1:0] reload_val;
  logic masked;

  assign ctrl_wr = wr_stb && (idx == IDX_W'(IDX_CTRL));
  assign load_wr = wr_stb && (idx == IDX_W'(IDX_LOAD));
  assign bgld_wr = wr_stb && (idx == IDX_W'(IDX_BGLD));
  assign raw_wr  = wr_stb && (idx == IDX_W'(IDX_RAW));

  assign advance    = ctrl_q.run && !ctrl_wr && !load_wr;
  assign expire     = advance && is_last(count_q);
  assign restart    = (ctrl_wr && wdata[0]) || (load_wr && ctrl_q.run);
  assign reload_val = bgld_wr ? wdata : load_q;
  assign masked     = raw_q && ctrl_q.irq_en;
  assign irq        = masked;

  // counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (ctrl_wr && wdata[0]) begin
      count_q <= load_q;
    end else if (load_wr && ctrl_q.run) begin
      count_q <= wdata;
    end else if (expire) begin
      count_q <= ctrl_q.one_shot ? '0 : reload_val;
    end else if (advance) begin
      count_q <= step_down(count_q);
    end
  end

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end else if (expire && ctrl_q.one_shot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  // load words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      bgld_q <= '0;
    end else begin
      if (load_wr || bgld_wr) load_q <= wdata;
      if (bgld_wr)            bgld_q <= wdata;
    end
  end

  // raw status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else if (expire) begin
      raw_q <= 1'b1;
    end else if (raw_wr && wdata[0]) begin
      raw_q <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (int'(idx))
      IDX_VALUE: rdata = count_q;
      IDX_LOAD:  rdata = load_q;
      IDX_BGLD:  rdata = bgld_q;
      IDX_CTRL:  rdata = DATA_W'(ctrl_q);
      IDX_RAW:   rdata = DATA_W'(raw_q);
      IDX_MASK:  rdata = DATA_W'(masked);
      default:   rdata = '0;
    endcase
  end

  // R3
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !expire) |=> (count_q == $past(count_q) - DATA_W'(1)));

  // R4
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.one_shot) |=> (!ctrl_q.run && count_q == '0));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && ctrl_q.run && !ctrl_wr) |=> (count_q == $past(wdata)));

  // R9
  bg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bgld_wr && advance && !expire) |=> (count_q == $past(count_q) - DATA_W'(1)));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ctrl_q.run);

endmodule

// File: rtl/twin_countdown_timer.sv
module twin_countdown_timer #(
  parameter int NUM_TIMERS  = 2,
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 8,
  parameter int ADDR_W      = 5,
  localparam int IDX_W      = $clog2(BLOCK_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_TIMERS-1:0] irq
);

  logic [IDX_W-1:0]      idx;
  logic [NUM_TIMERS-1:0] sel, wr_sel;
  logic [DATA_W-1:0]     ch_rdata [NUM_TIMERS];

  tmr_addr_decode #(
    .NUM_TIMERS (NUM_TIMERS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .idx   (idx),
    .sel   (sel),
    .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    tmr_channel #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
    ) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_stb(wr_sel[g]),
      .idx   (idx),
      .wdata (wdata),
      .rdata (ch_rdata[g]),
      .irq   (irq[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (sel[i]) rdata = rdata | ch_rdata[i];
    end
  end

  // R10
  oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (rdata == '0));

endmodule

// File: tb/twin_countdown_timer_bench.sv
module twin_countdown_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  twin_countdown_timer u_twin_countdown_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_ld  [2];
  logic [31:0] m_bg  [2];
  logic [2:0]  m_ctl [2];
  logic        m_raw [2];
  logic        m_exp [2];

  function automatic logic [31:0] ref_read(input logic [4:0] a);
    int t = int'(a[4:3]);
    if (t > 1) return 32'd0;
    case (int'(a[2:0]))
      0: return m_cnt[t];
      1: return m_ld[t];
      2: return m_bg[t];
      3: return {29'd0, m_ctl[t]};
      4: return {31'd0, m_raw[t]};
      5: return {31'd0, m_raw[t] & m_ctl[t][2]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    int t = int'(a[4:3]);
    if (t > 1 || a[2:0] > 3'd5) return "R10";
    case (int'(a[2:0]))
      0: return m_exp[t] ? (m_ctl[t][1] ? "R5" : "R4") : "R3";
      1: return "R8";
      2: return "R9";
      3: return "R2";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic ref_step(input logic w, input logic [4:0] a, input logic [31:0] d);
    for (int t = 0; t < 2; t++) begin
      logic hit = w && (int'(a[4:3]) == t);
      logic cw = hit && a[2:0] == 3'd3;
      logic lw = hit && a[2:0] == 3'd1;
      logic bw = hit && a[2:0] == 3'd2;
      logic rw = hit && a[2:0] == 3'd4;
      logic adv = m_ctl[t][0] && !cw && !lw;
      logic ex = adv && (m_cnt[t] <= 32'd1);
      logic [31:0] rl = bw ? d : m_ld[t];
      logic [31:0] nc = m_cnt[t];
      logic [2:0] nctl = m_ctl[t];
      if (cw && d[0]) nc = m_ld[t];
      else if (lw && m_ctl[t][0]) nc = d;
      else if (ex) nc = m_ctl[t][1] ? 32'd0 : rl;
      else if (adv) nc = m_cnt[t] - 32'd1;
      if (cw) nctl = d[2:0];
      else if (ex && m_ctl[t][1]) nctl[0] = 1'b0;
      if (ex) m_raw[t] = 1'b1;
      else if (rw && d[0]) m_raw[t] = 1'b0;
      if (lw || bw) m_ld[t] = d;
      if (bw) m_bg[t] = d;
      m_cnt[t] = nc;
      m_ctl[t] = nctl;
      m_exp[t] = ex;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %0d, t=%0t)", tag, act, exp, addr, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check pre-edge state, advance model
  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    #1;
    check(tag_of(a), rdata, ref_read(a));
    check("R7", {30'd0, irq}, {30'd0, m_raw[1] & m_ctl[1][2], m_raw[0] & m_ctl[0][2]});
    ref_step(w, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    for (int t = 0; t < 2; t++) begin
      m_cnt[t] = 0; m_ld[t] = 0; m_bg[t] = 0; m_ctl[t] = 0; m_raw[t] = 0; m_exp[t] = 0;
    end
    repeat (2) @(negedge clk);
    // R1: all words zero under reset
    for (int a = 0; a < 32; a++) begin
      addr = 5'(a); #1;
      check("R1", rdata, 32'd0);
    end
    check("R1", {30'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // directed: timer0 periodic with irq, timer1 one-shot
    cyc(1, 5'd1, 32'd4);
    cyc(1, 5'd3, 32'd5);
    repeat (6) cyc(0, 5'd0, 0);
    cyc(0, 5'd4, 0);
    cyc(1, 5'd4, 32'd0);          // R6: writing 0 keeps the flag
    cyc(0, 5'd4, 0);
    cyc(1, 5'd4, 32'd1);          // R6: writing 1 clears
    cyc(1, 5'd9, 32'd3);
    cyc(1, 5'd11, 32'd3);
    repeat (5) cyc(0, 5'd8, 0);
    cyc(0, 5'd11, 0);             // R5: run bit dropped
    cyc(1, 5'd10, 32'd7);         // R9 while timer0 runs
    repeat (8) cyc(0, 5'd0, 0);
    cyc(1, 5'd1, 32'd0);          // R8: zero load expires each cycle
    repeat (3) cyc(0, 5'd0, 0);
    cyc(1, 5'd20, 32'hFFFF_FFFF); // R10: out of range write
    cyc(0, 5'd20, 0);
    cyc(1, 5'd6, 32'hFFFF_FFFF);  // R10: unused index
    cyc(0, 5'd6, 0);
    cyc(1, 5'd3, 32'd0);          // R2: freeze
    repeat (3) cyc(0, 5'd0, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  a;
      logic [31:0] d;
      logic        w = ($urandom % 3) == 0;
      int          r = $urandom % 16;
      a = (r < 14) ? 5'(($urandom % 2) * 8 + ($urandom % 6)) : 5'($urandom);
      case (int'(a[2:0]))
        1, 2: d = 32'($urandom % 12 + 1);
        3: d = {29'($urandom), 2'($urandom), ($urandom % 4) != 0};
        default: d = $urandom;
      endcase
      cyc(w, a, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule